// File: doc/BRIEF.md
# Codec Control-Word Scheduler

This block is the host-side word engine for a two-section audio codec that sits behind a synchronous serial link. Out of reset the codec performs no conversions, so the scheduler first plays a fixed sixteen-entry table of 16-bit control writes. The table is generated on chip and paced by a sample-period strobe. A one-cycle pulse marks the moment the table pointer wraps. From then on every strobe opens a new sample period, and in each period the block hands words to a word-level transmit stream. It sends two DAC words in plain data mode. In mixed mode it also sends queued control writes, placed ahead of the DAC words.

Two framing policies govern how control writes share a period with DAC samples. Under the free-running policy, every control word that is queued when the strobe arrives goes out first, followed by both DAC words. Under the frame-locked policy a period always carries exactly two words, one slot per codec section. A queued control word takes over a slot and displaces that section's DAC update. The codec then repeats its previous sample, and the block raises a sample-repeated status for the rest of the period. On the receive side, ADC words pass through a valid/ready stream. Each word is tagged with its section and with a validity bit that is false for a powered-down converter or before initialization has finished.

The transmit stream follows valid/ready rules. While `tx_valid` is high and `tx_ready` is low, `tx_valid` and `tx_data` hold. A word transfers on a clock edge where both are high. The control-word input is also valid/ready, and `cw_ready` is low only when the queue is full. The receive path passes `adc_ready` straight back to `rx_ready`.

Top module: `codec_cw_sched`

## Requirements
- R1: After reset, `tx_valid`, `init_done`, `init_done_pulse`, `sample_repeat` and `cw_overflow` are 0 and `cw_ready` is 1.
- R2: Initialization word i (i = 0..15) has bit 15 = 1, bits 14:12 = 0, and the section bit s = 1 when i is even and 0 when i is odd, at bits 11 and 4. It carries the address a = ((i/2)+1) mod 8 at bits 10:8 and 2:0, and all other bits are 0. The words go out in index order, so addresses 1..7 come first and address 0 comes last.
- R3: With the default frame-locked initialization, each accepted strobe before `init_done` sends exactly two table words, one per section. No DAC word is sent before `init_done`.
- R4: `init_done_pulse` is high for exactly one cycle, in the cycle where the 16th table word is first presented. `init_done` rises at the same time and stays high.
- R5: In data mode a period sends the DAC words captured at the strobe, section 0 (`dac0_word`) then section 1 (`dac1_word`). The control queue is neither sent nor altered.
- R6: In free-running mixed mode, a period first sends the control words queued at the strobe, in arrival order, and then sends both DAC words.
- R7: In frame-locked mixed mode a period sends exactly two words. Slot k (k = 0, 1) carries the queue head if the queue is non-empty and DAC word k otherwise. `sample_repeat` is 1 after any slot was displaced and is cleared by the next accepted strobe.
- R8: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` is unchanged on the next cycle.
- R9: The control queue holds 4 words. When it is full, `cw_ready` is 0, and a word offered with `cw_valid` is dropped and sets `cw_overflow`. `cw_overflow` stays set until `ovf_clr` is pulsed.
- R10: The mode inputs `cfg_lock` and `cfg_mixed` are taken only while `init_done` is 1 and no period is in progress. A change made during a period does not affect that period and applies from the next one.
- R11: ADC words pass through with `adc_ch` = 0 for the first word after a strobe and 1 for the second. `adc_ok` is 1 only when `init_done` is 1 and `adc_pd[adc_ch]` is 0.
- R12: A strobe that arrives while a period is still in progress, including a last word still waiting on `tx_ready`, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| period_stb | input | 1 | Sample-period strobe |
| cfg_lock | input | 1 | Requested policy: 1 frame-locked, 0 free-running |
| cfg_mixed | input | 1 | Requested mode: 1 mixed, 0 data |
| dac0_word | input | 16 | DAC sample for section 0, captured at strobe |
| dac1_word | input | 16 | DAC sample for section 1, captured at strobe |
| adc_pd | input | 2 | Power-down flag per ADC section |
| cw_valid | input | 1 | Control word offered to the queue |
| cw_data | input | 16 | Control word |
| cw_ready | output | 1 | Queue can accept a word |
| ovf_clr | input | 1 | Clears the overflow flag |
| cw_overflow | output | 1 | Sticky: a word was offered while the queue was full |
| tx_valid | output | 1 | Transmit word valid |
| tx_data | output | 16 | Transmit word |
| tx_ready | input | 1 | Serial side accepts the word |
| rx_valid | input | 1 | Received ADC word valid |
| rx_data | input | 16 | Received ADC word |
| rx_ready | output | 1 | Receive back-pressure, equal to adc_ready |
| adc_valid | output | 1 | Tagged ADC word valid |
| adc_data | output | 16 | Tagged ADC word |
| adc_ch | output | 1 | ADC section of the word |
| adc_ok | output | 1 | ADC word is a real sample |
| adc_ready | input | 1 | Consumer accepts the ADC word |
| init_done | output | 1 | Initialization table has been sent |
| init_done_pulse | output | 1 | One-cycle pulse at table wrap |
| sample_repeat | output | 1 | A DAC update was displaced in this period |

## Verification
A wrong table pointer or burst counter appears on `tx_data` within the same period: a table word arrives out of order, or a period carries a word count other than two. The done pulse also lands in the wrong period. A sequencer that loses track of its slot or its queue snapshot changes the number or order of words in the very next period. A corrupted queue shows up later, when the stranded words come out in a later mixed period. A stuck mode register only shows up at the first period that follows a change of `cfg_lock` or `cfg_mixed`.

// File: rtl/codec_cw_pkg.sv
package codec_cw_pkg;

  localparam int CW_W = 16;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_INIT,
    SQ_CTL,
    SQ_DAC,
    SQ_LOCK
  } seq_state_e;

  // Table entry idx: pairs of writes to the same address, section 1 first.
  function automatic logic [CW_W-1:0] init_word(input int idx);
    logic       sec;
    logic [2:0] adr;
    sec = (idx % 2) == 0;
    adr = 3'(((idx / 2) + 1) % 8);
    return {1'b1, 3'b000, sec, adr, 3'b000, sec, 1'b0, adr};
  endfunction

endpackage

// File: rtl/cw_init_rom.sv
module cw_init_rom
  import codec_cw_pkg::*;
#(
  parameter int LEN = 16,
  localparam int PW = $clog2(LEN)
) (
  input  logic [PW-1:0]   idx,
  output logic [CW_W-1:0] word
);

  logic [CW_W-1:0] tbl [LEN];

  for (genvar g = 0; g < LEN; g++) begin : g_ent
    assign tbl[g] = init_word(g);
  end

  assign word = tbl[idx];

endmodule

// File: rtl/cw_fifo.sv
module cw_fifo #(
  parameter int W = 16,
  parameter int DEPTH = 4,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic [CW-1:0] count,
  output logic         full,
  output logic         empty
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_p, rd_p;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full  = count == CW'(DEPTH);
  assign empty = count == '0;
  assign dout  = mem[rd_p];

  always_ff @(posedge clk) begin
    if (push) mem[wr_p] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_p  <= '0;
      rd_p  <= '0;
      count <= '0;
    end else begin
      if (push) wr_p <= bump(wr_p);
      if (pop)  rd_p <= bump(rd_p);
      case ({push, pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/adc_tag.sv
module adc_tag #(
  parameter int W = 16,
  parameter int N_CH = 2,
  localparam int CHW = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            period_stb,
  input  logic            init_done,
  input  logic [N_CH-1:0] pd,
  input  logic            rx_valid,
  input  logic [W-1:0]    rx_data,
  output logic            rx_ready,
  output logic            adc_valid,
  output logic [W-1:0]    adc_data,
  output logic [CHW-1:0]  adc_ch,
  output logic            adc_ok,
  input  logic            adc_ready
);

  logic [CHW-1:0] ch;

  assign rx_ready  = adc_ready;
  assign adc_valid = rx_valid;
  assign adc_data  = rx_data;
  assign adc_ch    = ch;
  assign adc_ok    = init_done && !pd[ch];

  always_ff @(posedge clk) begin
    if (!rst_n || period_stb) begin
      ch <= '0;
    end else if (rx_valid && adc_ready) begin
      ch <= (ch == CHW'(N_CH - 1)) ? '0 : ch + CHW'(1);
    end
  end

endmodule

// File: rtl/codec_cw_sched.sv
module codec_cw_sched
  import codec_cw_pkg::*;
#(
  parameter int INIT_LEN    = 16,
  parameter int Q_DEPTH     = 4,
  parameter bit INIT_LOCKED = 1'b1,
  parameter int N_CH        = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            period_stb,
  input  logic            cfg_lock,
  input  logic            cfg_mixed,
  input  logic [CW_W-1:0] dac0_word,
  input  logic [CW_W-1:0] dac1_word,
  input  logic [N_CH-1:0] adc_pd,
  input  logic            cw_valid,
  input  logic [CW_W-1:0] cw_data,
  output logic            cw_ready,
  input  logic            ovf_clr,
  output logic            cw_overflow,
  output logic            tx_valid,
  output logic [CW_W-1:0] tx_data,
  input  logic            tx_ready,
  input  logic            rx_valid,
  input  logic [CW_W-1:0] rx_data,
  output logic            rx_ready,
  output logic            adc_valid,
  output logic [CW_W-1:0] adc_data,
  output logic            adc_ch,
  output logic            adc_ok,
  input  logic            adc_ready,
  output logic            init_done,
  output logic            init_done_pulse,
  output logic            sample_repeat
);

  localparam int PW    = $clog2(INIT_LEN);
  localparam int QCW   = $clog2(Q_DEPTH + 1);
  localparam int MAXV  = (INIT_LEN > Q_DEPTH) ? INIT_LEN : Q_DEPTH;
  localparam int LW    = $clog2(MAXV + 1);
  localparam int BURST = INIT_LOCKED ? N_CH : INIT_LEN;
  localparam logic [PW-1:0] LAST_IDX = PW'(INIT_LEN - 1);

  seq_state_e      st, nx_st;
  logic [PW-1:0]   ptr, nx_ptr;
  logic [LW-1:0]   left, nx_left;
  logic            slot, nx_slot;
  logic [CW_W-1:0] d0, d1, dac_sel;
  logic            txv;
  logic [CW_W-1:0] txd;
  logic            done_q, done_p, srep, ovf;
  logic            mode_lock, mode_mixed;

  logic            busy, can_load, stb_ok;
  logic            ld, q_pop, srep_set, fin;
  logic [CW_W-1:0] ld_word;

  logic [CW_W-1:0] rom_word;
  logic [CW_W-1:0] q_head;
  logic [QCW-1:0]  q_count;
  logic            q_full, q_empty, q_push;

  cw_init_rom #(.LEN(INIT_LEN)) u_rom (
    .idx  (ptr),
    .word (rom_word)
  );

  assign q_push   = cw_valid && !q_full;
  assign cw_ready = !q_full;

  cw_fifo #(.W(CW_W), .DEPTH(Q_DEPTH)) u_q (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (q_push),
    .din   (cw_data),
    .pop   (q_pop),
    .dout  (q_head),
    .count (q_count),
    .full  (q_full),
    .empty (q_empty)
  );

  adc_tag #(.W(CW_W), .N_CH(N_CH)) u_adc (
    .clk        (clk),
    .rst_n      (rst_n),
    .period_stb (period_stb),
    .init_done  (done_q),
    .pd         (adc_pd),
    .rx_valid   (rx_valid),
    .rx_data    (rx_data),
    .rx_ready   (rx_ready),
    .adc_valid  (adc_valid),
    .adc_data   (adc_data),
    .adc_ch     (adc_ch),
    .adc_ok     (adc_ok),
    .adc_ready  (adc_ready)
  );

  assign busy     = (st != SQ_IDLE) || txv;
  assign can_load = !txv || tx_ready;
  assign stb_ok   = period_stb && !busy;
  assign dac_sel  = slot ? d1 : d0;

  always_comb begin
    nx_st    = st;
    nx_ptr   = ptr;
    nx_left  = left;
    nx_slot  = slot;
    ld       = 1'b0;
    ld_word  = '0;
    q_pop    = 1'b0;
    srep_set = 1'b0;
    fin      = 1'b0;
    unique case (st)
      SQ_IDLE: begin
        if (stb_ok) begin
          nx_slot = 1'b0;
          if (!done_q) begin
            nx_st   = SQ_INIT;
            nx_left = LW'(BURST);
          end else if (!mode_mixed) begin
            nx_st = SQ_DAC;
          end else if (mode_lock) begin
            nx_st = SQ_LOCK;
          end else if (q_empty) begin
            nx_st = SQ_DAC;
          end else begin
            nx_st   = SQ_CTL;
            nx_left = LW'(q_count);
          end
        end
      end
      SQ_INIT: begin
        if (can_load) begin
          ld      = 1'b1;
          ld_word = rom_word;
          nx_ptr  = (ptr == LAST_IDX) ? '0 : ptr + PW'(1);
          nx_left = left - LW'(1);
          if (ptr == LAST_IDX) begin
            fin   = 1'b1;
            nx_st = SQ_IDLE;
          end else if (left == LW'(1)) begin
            nx_st = SQ_IDLE;
          end
        end
      end
      SQ_CTL: begin
        if (can_load) begin
          ld      = 1'b1;
          ld_word = q_head;
          q_pop   = 1'b1;
          nx_left = left - LW'(1);
          if (left == LW'(1)) begin
            nx_st   = SQ_DAC;
            nx_slot = 1'b0;
          end
        end
      end
      SQ_DAC: begin
        if (can_load) begin
          ld      = 1'b1;
          ld_word = dac_sel;
          nx_slot = 1'b1;
          if (slot) nx_st = SQ_IDLE;
        end
      end
      SQ_LOCK: begin
        if (can_load) begin
          ld      = 1'b1;
          nx_slot = 1'b1;
          if (!q_empty) begin
            ld_word  = q_head;
            q_pop    = 1'b1;
            srep_set = 1'b1;
          end else begin
            ld_word = dac_sel;
          end
          if (slot) nx_st = SQ_IDLE;
        end
      end
      default: nx_st = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= SQ_IDLE;
      ptr        <= '0;
      left       <= '0;
      slot       <= 1'b0;
      d0         <= '0;
      d1         <= '0;
      txv        <= 1'b0;
      txd        <= '0;
      done_q     <= 1'b0;
      done_p     <= 1'b0;
      srep       <= 1'b0;
      ovf        <= 1'b0;
      mode_lock  <= INIT_LOCKED;
      mode_mixed <= 1'b0;
    end else begin
      st     <= nx_st;
      ptr    <= nx_ptr;
      left   <= nx_left;
      slot   <= nx_slot;
      done_p <= fin;
      if (fin) done_q <= 1'b1;
      if (stb_ok) begin
        d0 <= dac0_word;
        d1 <= dac1_word;
      end
      if (can_load) txv <= ld;
      if (ld) txd <= ld_word;
      if (srep_set)    srep <= 1'b1;
      else if (stb_ok) srep <= 1'b0;
      if (cw_valid && q_full) ovf <= 1'b1;
      else if (ovf_clr)       ovf <= 1'b0;
      if (done_q && !busy) begin
        mode_lock  <= cfg_lock;
        mode_mixed <= cfg_mixed;
      end
    end
  end

  assign tx_valid        = txv;
  assign tx_data         = txd;
  assign init_done       = done_q;
  assign init_done_pulse = done_p;
  assign sample_repeat   = srep;
  assign cw_overflow     = ovf;

endmodule

// File: rtl/codec_cw_sched_chk.sv
module codec_cw_sched_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic [15:0] tx_data,
  input logic        init_done,
  input logic        init_done_pulse,
  input logic        cw_valid,
  input logic        cw_ready,
  input logic        cw_overflow,
  input logic        adc_ok,
  input logic        sample_repeat
);

  // R8
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done_pulse |=> !init_done_pulse);

  // R4
  done_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done_pulse |-> init_done);

  // R4
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  // R2
  ctl_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !init_done) |-> tx_data[15]);

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cw_valid && !cw_ready) |=> cw_overflow);

  // R11
  adc_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> !adc_ok);

  // R7
  srep_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> !sample_repeat);

endmodule

bind codec_cw_sched codec_cw_sched_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .tx_valid        (tx_valid),
  .tx_ready        (tx_ready),
  .tx_data         (tx_data),
  .init_done       (init_done),
  .init_done_pulse (init_done_pulse),
  .cw_valid        (cw_valid),
  .cw_ready        (cw_ready),
  .cw_overflow     (cw_overflow),
  .adc_ok          (adc_ok),
  .sample_repeat   (sample_repeat)
);

// File: tb/codec_cw_sched_tb.sv
module codec_cw_sched_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic period_stb = 1'b0, cfg_lock = 1'b1, cfg_mixed = 1'b0;
  logic [15:0] dac0_word = '0, dac1_word = '0;
  logic [1:0]  adc_pd = '0;
  logic cw_valid = 1'b0;
  logic [15:0] cw_data = '0;
  logic cw_ready, ovf_clr = 1'b0, cw_overflow;
  logic tx_valid, tx_ready = 1'b1;
  logic [15:0] tx_data;
  logic rx_valid = 1'b0, rx_ready, adc_valid, adc_ch, adc_ok, adc_ready = 1'b1;
  logic [15:0] rx_data = '0, adc_data;
  logic init_done, init_done_pulse, sample_repeat;

  always #5 clk = ~clk;

  codec_cw_sched u_dut (
    .clk(clk), .rst_n(rst_n), .period_stb(period_stb), .cfg_lock(cfg_lock),
    .cfg_mixed(cfg_mixed), .dac0_word(dac0_word), .dac1_word(dac1_word),
    .adc_pd(adc_pd), .cw_valid(cw_valid), .cw_data(cw_data), .cw_ready(cw_ready),
    .ovf_clr(ovf_clr), .cw_overflow(cw_overflow), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ready(rx_ready), .adc_valid(adc_valid), .adc_data(adc_data),
    .adc_ch(adc_ch), .adc_ok(adc_ok), .adc_ready(adc_ready),
    .init_done(init_done), .init_done_pulse(init_done_pulse),
    .sample_repeat(sample_repeat)
  );

  int total = 0, bad = 0;
  logic [15:0] log_w [0:255];
  int log_n = 0;
  int pulse_cnt = 0;
  bit stall_en = 0, hold_low = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit prev_stall = 0;
  logic [15:0] prev_d = '0;

  logic [15:0] mq [0:3];
  int mq_h = 0, mq_n = 0;
  logic [15:0] ex_w [0:31];
  int ex_n = 0;
  bit ex_srep = 0;
  bit b_lock = 1, b_mixed = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // transmit-side monitor and back-pressure driver
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall) begin
        if (!tx_valid || tx_data != prev_d)
          chk(0, "R8 hold", int'(tx_data), int'(prev_d));
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      tx_ready = hold_low ? 1'b0 : (stall_en ? lfsr[0] : 1'b1);
      if (tx_valid && tx_ready) begin
        log_w[log_n[7:0]] = tx_data;
        log_n++;
      end
      if (init_done_pulse) pulse_cnt++;
      prev_stall = tx_valid && !tx_ready;
      prev_d = tx_data;
    end
  end

  function automatic logic [15:0] tbl_word(input int i);
    int a;
    int s;
    a = ((i / 2) + 1) % 8;
    s = (i % 2 == 0) ? 1 : 0;
    return 16'(32'h8000 + (s << 11) + (a << 8) + (s << 4) + a);
  endfunction

  task automatic push(input logic [15:0] v);
    @(negedge clk);
    chk(cw_ready == (mq_n < 4), "R9 ready", int'(cw_ready), int'(mq_n < 4));
    cw_valid = 1'b1;
    cw_data = v;
    if (mq_n < 4) begin
      mq[(mq_h + mq_n) % 4] = v;
      mq_n++;
    end
    @(negedge clk);
    cw_valid = 1'b0;
  endtask

  function automatic logic [15:0] mpop();
    logic [15:0] v;
    v = mq[mq_h];
    mq_h = (mq_h + 1) % 4;
    mq_n--;
    return v;
  endfunction

  // Build the expected word list for a period from the mode model.
  task automatic build_exp(input logic [15:0] a, input logic [15:0] b);
    ex_n = 0;
    ex_srep = 0;
    if (b_mixed && b_lock) begin
      for (int k = 0; k < 2; k++) begin
        if (mq_n > 0) begin
          ex_w[ex_n] = mpop();
          ex_srep = 1;
        end else begin
          ex_w[ex_n] = (k == 0) ? a : b;
        end
        ex_n++;
      end
    end else begin
      if (b_mixed) begin
        for (int k = mq_n; k > 0; k--) begin
          ex_w[ex_n] = mpop();
          ex_n++;
        end
      end
      ex_w[ex_n] = a; ex_n++;
      ex_w[ex_n] = b; ex_n++;
    end
  endtask

  task automatic run_period(input logic [15:0] a, input logic [15:0] b,
                            input bit dbl, input bit midchg, input string req);
    int base;
    @(negedge clk);
    dac0_word = a;
    dac1_word = b;
    period_stb = 1'b1;
    base = log_n;
    @(negedge clk);
    period_stb = 1'b0;
    dac0_word = ~a;
    dac1_word = ~b;
    @(negedge clk);
    if (dbl) period_stb = 1'b1;
    @(negedge clk);
    period_stb = 1'b0;
    if (midchg) begin
      cfg_lock = 1'b0;
      cfg_mixed = 1'b0;
      repeat (4) @(negedge clk);
      hold_low = 0;
    end
    repeat (60) @(negedge clk);
    #1;
    chk(log_n - base == ex_n, req, log_n - base, ex_n);
    for (int i = 0; i < ex_n; i++)
      chk(log_w[(base + i) % 256] == ex_w[i], req, int'(log_w[(base + i) % 256]), int'(ex_w[i]));
  endtask

  task automatic set_mode(input bit lk, input bit mx);
    @(negedge clk);
    cfg_lock = lk;
    cfg_mixed = mx;
    b_lock = lk;
    b_mixed = mx;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    chk(tx_valid == 0, "R1 tx_valid", int'(tx_valid), 0);
    chk(init_done == 0, "R1 init_done", int'(init_done), 0);
    chk(cw_overflow == 0, "R1 overflow", int'(cw_overflow), 0);
    chk(cw_ready == 1, "R1 cw_ready", int'(cw_ready), 1);
    chk(sample_repeat == 0, "R1 srep", int'(sample_repeat), 0);

    // R11 before init: word tagged invalid
    @(negedge clk);
    rx_valid = 1'b1; rx_data = 16'h1234; #1;
    chk(adc_valid && adc_ok == 0, "R11 pre-init", int'(adc_ok), 0);
    @(negedge clk);
    rx_valid = 1'b0;

    // R2 R3 R4 R12: initialization, two table words per period
    stall_en = 1;
    for (int p = 0; p < 8; p++) begin
      ex_n = 2;
      ex_w[0] = tbl_word(2 * p);
      ex_w[1] = tbl_word(2 * p + 1);
      run_period(16'h7000 + 16'(p), 16'h7100, p == 0, 0, p == 0 ? "R12 R3 R2" : "R3 R2");
      if (p < 7) begin
        chk(init_done == 0, "R3 not done", int'(init_done), 0);
        chk(pulse_cnt == 0, "R4 early pulse", pulse_cnt, 0);
      end
    end
    chk(init_done == 1, "R4 done", int'(init_done), 1);
    chk(pulse_cnt == 1, "R4 pulse count", pulse_cnt, 1);

    // R5 data mode; a queued word is left untouched
    set_mode(1'b0, 1'b0);
    push(16'hC0DE);
    for (int i = 0; i < 4; i++) begin
      stall_en = i[0];
      build_exp(16'(16'h1111 * (i + 1)), 16'(16'h0F0F + i * 3));
      run_period(16'(16'h1111 * (i + 1)), 16'(16'h0F0F + i * 3), 0, 0, "R5");
    end

    // R6 free-running mixed, queue depths swept
    set_mode(1'b0, 1'b1);
    for (int s = 0; s < 2; s++) begin
      stall_en = s[0];
      for (int n = 0; n < 4; n++) begin
        for (int j = 0; j < n; j++) push(16'(16'hA000 + n * 16 + j));
        build_exp(16'(16'h2000 + n), 16'(16'h3000 + n));
        run_period(16'(16'h2000 + n), 16'(16'h3000 + n), 0, 0, "R6");
        chk(sample_repeat == 0, "R6 srep", int'(sample_repeat), 0);
      end
    end

    // R9 overflow
    for (int j = 0; j < 4; j++) push(16'(16'hB000 + j));
    push(16'hBEEF);
    #1;
    chk(cw_overflow == 1, "R9 set", int'(cw_overflow), 1);
    build_exp(16'h4444, 16'h5555);
    run_period(16'h4444, 16'h5555, 0, 0, "R9 R6");
    chk(cw_overflow == 1, "R9 sticky", int'(cw_overflow), 1);
    @(negedge clk); ovf_clr = 1'b1;
    @(negedge clk); ovf_clr = 1'b0; #1;
    chk(cw_overflow == 0, "R9 clear", int'(cw_overflow), 0);

    // R7 frame-locked mixed
    set_mode(1'b1, 1'b1);
    for (int s = 0; s < 2; s++) begin
      stall_en = s[0];
      for (int n = 0; n < 4; n++) begin
        for (int j = 0; j < n; j++) push(16'(16'hD000 + n * 16 + j));
        build_exp(16'(16'h6000 + n), 16'(16'h6100 + n));
        run_period(16'(16'h6000 + n), 16'(16'h6100 + n), 0, 0, "R7");
        chk(sample_repeat == ex_srep, "R7 srep", int'(sample_repeat), int'(ex_srep));
      end
    end
    // drain leftovers
    while (mq_n > 0) begin
      build_exp(16'h0101, 16'h0202);
      run_period(16'h0101, 16'h0202, 0, 0, "R7 drain");
    end

    // R10 mode change during a stalled period is deferred
    stall_en = 0;
    push(16'hE001);
    push(16'hE002);
    build_exp(16'h7777, 16'h8888);
    hold_low = 1;
    run_period(16'h7777, 16'h8888, 0, 1, "R10 locked kept");
    chk(sample_repeat == 1, "R10 R7 srep", int'(sample_repeat), 1);
    b_lock = 0; b_mixed = 0;
    build_exp(16'h9999, 16'hAAAA);
    run_period(16'h9999, 16'hAAAA, 0, 0, "R10 data after");
    chk(sample_repeat == 0, "R7 srep cleared", int'(sample_repeat), 0);

    // R11 ADC tagging, all power-down patterns
    for (int pd = 0; pd < 4; pd++) begin
      adc_pd = 2'(pd);
      build_exp(16'(pd), 16'(pd + 8));
      run_period(16'(pd), 16'(pd + 8), 0, 0, "R5 R11");
      @(negedge clk);
      rx_valid = 1'b1; rx_data = 16'(16'h5A00 + pd); #1;
      chk(adc_ch == 0 && adc_data == 16'(16'h5A00 + pd), "R11 ch0", int'(adc_ch), 0);
      chk(adc_ok == !adc_pd[0], "R11 ok0", int'(adc_ok), int'(!adc_pd[0]));
      @(negedge clk); #1;
      chk(adc_ch == 1, "R11 ch1", int'(adc_ch), 1);
      chk(adc_ok == !adc_pd[1], "R11 ok1", int'(adc_ok), int'(!adc_pd[1]));
      @(negedge clk);
      rx_valid = 1'b0;
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule